// File: doc/BRIEF.md
# Multi-Mode Fracturable Logic Cell

This block is one logic cell of a small programmable fabric. It holds a 16-entry truth table that can be read as a single 4-input function or split into two 3-input functions, plus two flip-flops. A static configuration word picks one of three operating modes: a full 4-input function feeding the lower flip-flop, two 3-input functions each feeding its own flip-flop, or a two-stage shift register fed serially from function input 0.

Each of the two outputs is steered by its own configuration bit to either the flip-flop value or the combinational value that feeds that flip-flop. A test-enable input reroutes both flip-flops into a two-stage scan path (scan input into stage 0, stage 0 into stage 1, stage 1 onto the scan output), so the captured contents can be shifted out for readback and chained through neighbouring cells. The configuration inputs are held static by the surrounding fabric. Loading them and routing between cells are handled elsewhere.

Top module: `ple_cell`

## Requirements
- R1: A synchronous active-high reset clears both flip-flops at the clock edge. Reset takes priority over test enable and over every mode.
- R2: With mode code 2'b00 and output-select bit 0 low, out_o[0] equals cfg_truth indexed by lut_in as a 4-bit number (lut_in[3] is the most significant bit).
- R3: With mode code 2'b00 and test enable low, flip-flop 0 captures the 4-input function value at each edge and flip-flop 1 loads 0. The combinational value of output 1 is 0.
- R4: With mode code 2'b01, the combinational value of output 0 is cfg_truth[lut_in[2:0]] and that of output 1 is cfg_truth[8 + lut_in[2:0]]. lut_in[3] has no effect on either output.
- R5: With mode code 2'b01 and test enable low, flip-flop 0 captures the lower-half function and flip-flop 1 captures the upper-half function at each edge.
- R6: With mode code 2'b10 and test enable low, flip-flop 0 loads lut_in[0] and flip-flop 1 loads the previous value of flip-flop 0. The combinational value of output 0 is lut_in[0] and that of output 1 is flip-flop 0.
- R7: With test enable high and reset low, flip-flop 0 loads scan_in and flip-flop 1 loads the previous value of flip-flop 0, whatever the mode code.
- R8: scan_out always shows flip-flop 1.
- R9: Mode code 2'b11 behaves exactly like mode code 2'b00.
- R10: For each output i, cfg_oreg[i] high selects flip-flop i and low selects the combinational value of that output as defined for the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of both flip-flops |
| cfg_truth | input | 16 | Truth table; entry n is the function value for index n |
| cfg_mode | input | 2 | Mode code: 00 full 4-input, 01 split 3-input pair, 10 shift register, 11 same as 00 |
| cfg_oreg | input | 2 | Per-output select: 1 registered, 0 combinational |
| lut_in | input | 4 | Function inputs; bit 0 is also the serial input in shift mode |
| test_en | input | 1 | High turns both flip-flops into a scan path |
| scan_in | input | 1 | Serial scan input into flip-flop 0 |
| scan_out | output | 1 | Serial scan output, the value of flip-flop 1 |
| out_o | output | 2 | Cell outputs, each registered or combinational per cfg_oreg |

## Verification
The bound checker watches, on every clock, the next-state rules that depend only on the previous state and inputs: the reset clear, the scan shift under test enable, the shift-register mode chain, the forced zero in the upper flip-flop for mode codes 00 and 11, the agreement of a registered output 1 with the scan output, and the pass-through of lut_in[0] in shift mode. Whether the truth table is indexed correctly in full and split modes, that lut_in[3] is ignored when split, and that a loaded pattern reads back in order over the scan path can only be shown by the bench, which runs random truth tables, inputs, output selects and mode changes against its own model and shifts out known captured values.

// File: rtl/ple_pkg.sv
package ple_pkg;

    localparam int unsigned LUT_K   = 4;
    localparam int unsigned NUM_FF  = 2;
    localparam int unsigned TT_W    = 1 << LUT_K;
    localparam int unsigned HALF_W  = TT_W / 2;

    typedef enum logic [1:0] {
        MODE_FULL4  = 2'b00,
        MODE_SPLIT3 = 2'b01,
        MODE_SHIFT  = 2'b10,
        MODE_ALT4   = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic                 full;
        logic [NUM_FF-1:0]    half;
    } lut_res_t;

    function automatic logic uses_full(cell_mode_e m);
        return (m == MODE_FULL4) || (m == MODE_ALT4);
    endfunction

endpackage

// File: rtl/ple_frac_lut.sv
module ple_frac_lut
    import ple_pkg::*;
#(
    parameter int unsigned K = LUT_K
) (
    input  logic [(1<<K)-1:0] tt,
    input  logic [K-1:0]      sel,
    output lut_res_t          res
);
    localparam int unsigned TW = 1 << K;
    localparam int unsigned HW = TW / 2;

    logic [HW-1:0] half_tt [NUM_FF];

    assign res.full = tt[sel];

    for (genvar h = 0; h < NUM_FF; h++) begin : g_half
        assign half_tt[h]  = tt[h*HW +: HW];
        assign res.half[h] = half_tt[h][sel[K-2:0]];
    end

endmodule

// File: rtl/ple_ff_pair.sv
module ple_ff_pair
    import ple_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic              scan_in,
    input  cell_mode_e        mode,
    input  lut_res_t          lut,
    input  logic              ser_in,
    output logic [NUM_FF-1:0] q
);
    logic [NUM_FF-1:0] d;

    always_comb begin
        if (test_en) begin
            d = {q[0], scan_in};
        end else begin
            case (mode)
                MODE_SPLIT3: d = lut.half;
                MODE_SHIFT:  d = {q[0], ser_in};
                default:     d = {1'b0, lut.full};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/ple_out_sel.sv
module ple_out_sel
    import ple_pkg::*;
(
    input  cell_mode_e        mode,
    input  lut_res_t          lut,
    input  logic              ser_in,
    input  logic [NUM_FF-1:0] q,
    input  logic [NUM_FF-1:0] oreg,
    output logic [NUM_FF-1:0] out
);
    logic [NUM_FF-1:0] comb_v;

    always_comb begin
        if (uses_full(mode)) begin
            comb_v = {1'b0, lut.full};
        end else if (mode == MODE_SPLIT3) begin
            comb_v = lut.half;
        end else begin
            comb_v = {q[0], ser_in};
        end
    end

    for (genvar i = 0; i < NUM_FF; i++) begin : g_out
        assign out[i] = oreg[i] ? q[i] : comb_v[i];
    end

endmodule

// File: rtl/ple_cell.sv
module ple_cell
    import ple_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [TT_W-1:0]     cfg_truth,
    input  logic [1:0]          cfg_mode,
    input  logic [NUM_FF-1:0]   cfg_oreg,
    input  logic [LUT_K-1:0]    lut_in,
    input  logic                test_en,
    input  logic                scan_in,
    output logic                scan_out,
    output logic [NUM_FF-1:0]   out_o
);
    cell_mode_e        mode;
    lut_res_t          lut_v;
    logic [NUM_FF-1:0] ff_q;

    assign mode = cell_mode_e'(cfg_mode);

    ple_frac_lut #(.K(LUT_K)) u_lut (
        .tt  (cfg_truth),
        .sel (lut_in),
        .res (lut_v)
    );

    ple_ff_pair u_ffs (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .scan_in (scan_in),
        .mode    (mode),
        .lut     (lut_v),
        .ser_in  (lut_in[0]),
        .q       (ff_q)
    );

    ple_out_sel u_osel (
        .mode   (mode),
        .lut    (lut_v),
        .ser_in (lut_in[0]),
        .q      (ff_q),
        .oreg   (cfg_oreg),
        .out    (out_o)
    );

    assign scan_out = ff_q[NUM_FF-1];

endmodule

// File: rtl/ple_cell_chk.sv
module ple_cell_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic [1:0] cfg_oreg,
    input logic [3:0] lut_in,
    input logic       test_en,
    input logic       scan_in,
    input logic       scan_out,
    input logic [1:0] out_o,
    input logic [1:0] ff_q
);
    // R1: reset clears both stages
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ff_q == 2'b00));

    // R7: scan shift under test enable
    a_r7_scan_shift: assert property (@(posedge clk) disable iff (rst)
        test_en |=> (ff_q == {$past(ff_q[0]), $past(scan_in)}));

    // R6: shift-register chain
    a_r6_shift_chain: assert property (@(posedge clk) disable iff (rst)
        (!test_en && cfg_mode == 2'b10) |=> (ff_q == {$past(ff_q[0]), $past(lut_in[0])}));

    // R3 / R9: upper stage idle in full modes
    a_r3_upper_idle: assert property (@(posedge clk) disable iff (rst)
        (!test_en && cfg_mode[1] == cfg_mode[0]) |=> (ff_q[1] == 1'b0));

    // R8: registered output 1 agrees with scan output
    a_r8_scan_tap: assert property (@(posedge clk) disable iff (rst)
        cfg_oreg[1] |-> (out_o[1] == scan_out));

    // R10 / R6: combinational output 0 passes serial input in shift mode
    a_r10_comb_pass: assert property (@(posedge clk) disable iff (rst)
        (!cfg_oreg[0] && cfg_mode == 2'b10) |-> (out_o[0] == lut_in[0]));

endmodule

bind ple_cell ple_cell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .cfg_oreg (cfg_oreg),
    .lut_in   (lut_in),
    .test_en  (test_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .out_o    (out_o),
    .ff_q     (ff_q)
);

// File: tb/test_ple_cell.sv
module test_ple_cell;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_truth;
    logic [1:0]  cfg_mode;
    logic [1:0]  cfg_oreg;
    logic [3:0]  lut_in;
    logic        test_en;
    logic        scan_in;
    logic        scan_out;
    logic [1:0]  out_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit m0 = 1'b0;
    bit m1 = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ple_cell i_ple_cell (
        .clk       (clk),
        .rst       (rst),
        .cfg_truth (cfg_truth),
        .cfg_mode  (cfg_mode),
        .cfg_oreg  (cfg_oreg),
        .lut_in    (lut_in),
        .test_en   (test_en),
        .scan_in   (scan_in),
        .scan_out  (scan_out),
        .out_o     (out_o)
    );

    task automatic check(string tag, string what, logic act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // one clock: compare outputs mid-cycle, then advance the model
    task automatic step(string tag);
        bit c0, c1, e0, e1;
        int idx;
        #2;
        idx = int'(lut_in);
        case (cfg_mode)
            2'b01: begin
                c0 = cfg_truth[idx % 8];
                c1 = cfg_truth[8 + (idx % 8)];
            end
            2'b10: begin
                c0 = lut_in[0];
                c1 = m0;
            end
            default: begin
                c0 = cfg_truth[idx];
                c1 = 1'b0;
            end
        endcase
        e0 = cfg_oreg[0] ? m0 : c0;
        e1 = cfg_oreg[1] ? m1 : c1;
        check(tag, "out_o[0]", out_o[0], e0);
        check(tag, "out_o[1]", out_o[1], e1);
        check(tag, "scan_out (R8)", scan_out, m1);
        @(posedge clk);
        if (rst) begin
            m0 = 1'b0; m1 = 1'b0;
        end else if (test_en) begin
            m1 = m0; m0 = scan_in;
        end else if (cfg_mode == 2'b01) begin
            m0 = c0; m1 = c1;
        end else if (cfg_mode == 2'b10) begin
            m1 = m0; m0 = lut_in[0];
        end else begin
            m0 = c0; m1 = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic rand_run(string tag, logic [1:0] mode, int n, bit use_test);
        cfg_mode = mode;
        for (int k = 0; k < n; k++) begin
            if (k % 16 == 0) cfg_truth = 16'($urandom);
            cfg_oreg = 2'($urandom);
            lut_in   = 4'($urandom);
            scan_in  = 1'($urandom);
            test_en  = use_test ? ((($urandom) % 4) == 0) : 1'b0;
            step(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_truth = 16'hFFFF; cfg_mode = 2'b01; cfg_oreg = 2'b11;
        lut_in = 4'hF; test_en = 1'b1; scan_in = 1'b1;
        @(posedge clk); @(negedge clk);
        m0 = 1'b0; m1 = 1'b0;
        // R1: reset held with every input driving ones
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;

        rand_run("R2 R3 R10 full", 2'b00, 400, 1'b0);
        rand_run("R4 R5 R10 split", 2'b01, 400, 1'b0);

        // R4: lut_in[3] ignored in split mode, combinational outputs
        cfg_mode = 2'b01; cfg_oreg = 2'b00; test_en = 1'b0;
        for (int k = 0; k < 32; k++) begin
            cfg_truth = 16'($urandom);
            lut_in = {1'b0, 3'($urandom)};
            step("R4 upper bit low");
            lut_in[3] = 1'b1;
            step("R4 upper bit high");
        end

        rand_run("R6 R10 shift", 2'b10, 400, 1'b0);
        rand_run("R9 alt full", 2'b11, 300, 1'b0);
        rand_run("R7 R8 scan mixed", 2'($urandom), 300, 1'b1);

        // R7 R8: capture known values in split mode, then read them back
        cfg_mode = 2'b01; cfg_oreg = 2'b11; test_en = 1'b0;
        cfg_truth = 16'h0F01;    // lower half: entry 0 = 1, upper half: entry 0 = 1
        lut_in = 4'h0;
        step("R5 capture 11");
        cfg_truth = 16'h0001;    // lower=1, upper=0
        step("R5 capture 01");
        test_en = 1'b1; scan_in = 1'b0;
        step("R7 readback first");
        step("R7 readback second");
        step("R7 readback drained");

        // mixed mode changes with scan, then a mid-run reset
        for (int k = 0; k < 200; k++) begin
            rand_run("R3 R5 R6 R7 mixed", 2'($urandom), 4, 1'b1);
        end
        rst = 1'b1;
        step("R1 midrun reset");
        rst = 1'b0;
        cfg_oreg = 2'b11;
        step("R1 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule